// File: doc/BRIEF.md
# DAC Row/Column Diagnosis Sequencer

This controller runs the structural test of a thermometer-coded current-steering DAC whose unit cells sit in a ROWS x COLS matrix. Test starts with a `start` pulse. In the first phase, the controller walks a short ramp of thermometer codes. The first code has no cells on, and each later code turns on one more cell. At each code an external measurement path captures the output current, and those readings feed an off-chip process-variation estimate. The number of ramp steps is an input and may be zero. Six steps is the usual setting.

In the second phase, the controller puts the decoder into test mode. It enables one row at a time with every column enabled, and then one column at a time with every row enabled. Each selection is held until the measurement path returns a signed digitized current sum. The controller then checks every row sum against the mean of the other row sums, and does the same for the columns. The comparison uses the exact mean, with no division and no rounding. A row or column is flagged when its sum departs from that mean by more than a programmable threshold. The diagnosis needs only ROWS + COLS measurements.

There are three possible results:
- **Pass**: no row and no column is flagged.
- **Fault found**: exactly one row and exactly one column are flagged. The controller reports their indices as the suspect cell.
- **Ambiguous**: any other pattern of flags.

The result stays valid while `done` is high. `done` stays high until the next `start`.

Top module: `dac_diag_seq`

## Requirements
- R1: After a synchronous reset the block is idle, with these outputs all low: `meas_req`, `done`, `test_sel`, `dac_code`, `row_en`, `col_en`, and the three result flags.
- R2: `start` latches `est_steps`. The block then makes `est_steps` measurements with `test_sel` low. At step k (counting from 0), bits 0..k-1 of `dac_code` are 1 and all other bits are 0, with bit i driving cell i.
- R3: When `est_steps` is 0, the estimation phase is skipped and the first measurement is already a row selection.
- R4: The row phase has ROWS measurements, with `test_sel` high, `row_en` one-hot stepping from bit 0 upward, and `col_en` all ones. The column phase follows with COLS measurements, `col_en` one-hot stepping from bit 0 upward and `row_en` all ones. In total there are exactly est_steps + ROWS + COLS measurements.
- R5: A measurement completes only on a cycle where `meas_req` and `meas_valid` are both high. While `meas_req` is high and `meas_valid` is low, `meas_req`, `dac_code`, `row_en`, `col_en` and `test_sel` hold their values. `meas_valid` has no effect while idle or done.
- R6: Entry i of a group of N sums is flagged when |s_i - (T - s_i)/(N-1)| > `threshold`, where T is the group total. The mean is taken exactly, with no truncation. A deviation equal to `threshold` is not flagged. Sums are two's complement.
- R7: When exactly one row and exactly one column are flagged, `fault_found` is set. `fault_row` and `fault_col` then give their binary indices, where index r means `row_en` bit r and index c means `col_en` bit c.
- R8: When no row and no column is flagged, `pass` is set.
- R9: Any other flag pattern sets `ambiguous`. While `done` is high, exactly one of `pass`, `fault_found` and `ambiguous` is high.
- R10: `done` and the result outputs stay unchanged until the next `start`. Once `start` is seen, `done` and the result flags are low from the following cycle, and `start` has no effect while a test is running.
- R11: A synchronous reset asserted in the middle of a run returns the block to the R1 state on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a test sequence when idle or done |
| est_steps | input | STEP_W | Number of estimation ramp steps, latched at start |
| threshold | input | SUM_W | Unsigned deviation limit for flagging |
| meas_valid | input | 1 | Measurement for the current selection is present |
| meas_sum | input | SUM_W | Signed digitized current sum |
| meas_req | output | 1 | A measurement is requested for the present selection |
| test_sel | output | 1 | Decoder test mode enable |
| dac_code | output | ROWS*COLS | Thermometer code during estimation |
| row_en | output | ROWS | Row enables in test mode |
| col_en | output | COLS | Column enables in test mode |
| done | output | 1 | Result valid, held until next start |
| pass | output | 1 | Nothing flagged |
| fault_found | output | 1 | Single row and single column flagged |
| ambiguous | output | 1 | Any other flag pattern |
| fault_row | output | clog2(ROWS) | Flagged row index |
| fault_col | output | clog2(COLS) | Flagged column index |

## Verification
The assertions check, on every cycle:
- the state right after reset;
- that the selection and code stay stable while a request waits for `meas_valid`;
- that row and column enables are one-hot or all-ones in test mode;
- that exactly one result flag is set while `done` is high;
- that `done` persists until `start`.

Only the bench scenarios show the remaining behaviour:
- the ramp codes and their count;
- the row-then-column visiting order;
- that the exact mean is used instead of a truncated one;
- strictness at the threshold boundary;
- handling of negative sums;
- the diagnosed cell indices.

// File: rtl/dac_diag_pkg.sv
package dac_diag_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_EST  = 3'd1,
      ST_ROW  = 3'd2,
      ST_COL  = 3'd3,
      ST_EVAL = 3'd4,
      ST_DONE = 3'd5
   } seq_state_t;

   typedef struct packed {
      logic pass;
      logic fault;
      logic ambig;
   } verdict_t;

endpackage

// File: rtl/dac_diag_therm.sv
module dac_diag_therm #(
   parameter int CELLS  = 16,
   parameter int STEP_W = 5
) (
   input  logic [STEP_W-1:0] level,
   output logic [CELLS-1:0]  code
);

   if (CELLS >= (1 << STEP_W)) begin : g_bad_width
      $error("dac_diag_therm: STEP_W too narrow for CELLS");
   end

   // Cell i is on when the level exceeds i; the code saturates at full scale.
   for (genvar i = 0; i < CELLS; i++) begin : g_cell
      assign code[i] = (level > STEP_W'(i));
   end

endmodule

// File: rtl/dac_diag_outlier.sv
module dac_diag_outlier #(
   parameter int N     = 4,
   parameter int SUM_W = 16
) (
   input  logic [N*SUM_W-1:0] sums,
   input  logic [SUM_W-1:0]   threshold,
   output logic [N-1:0]       flags
);

   localparam int EXT_W = SUM_W + $clog2(N) + 3;

   if (N < 2) begin : g_bad_n
      $error("dac_diag_outlier: need at least two entries");
   end

   logic signed [EXT_W-1:0] total;
   logic signed [EXT_W-1:0] nm1;
   logic signed [EXT_W-1:0] lim;

   assign nm1 = $signed(EXT_W'(N - 1));
   assign lim = $signed(EXT_W'(threshold)) * nm1;

   always_comb begin
      total = '0;
      for (int k = 0; k < N; k++) begin
         total = total + EXT_W'($signed(sums[k*SUM_W +: SUM_W]));
      end
   end

   // Scaled comparison: |(N-1)*s - others| > (N-1)*thr is exact.
   for (genvar i = 0; i < N; i++) begin : g_ent
      logic signed [EXT_W-1:0] s_ext;
      logic signed [EXT_W-1:0] diff;
      logic signed [EXT_W-1:0] mag;
      assign s_ext = EXT_W'($signed(sums[i*SUM_W +: SUM_W]));
      assign diff  = (s_ext * nm1) - (total - s_ext);
      assign mag   = diff[EXT_W-1] ? -diff : diff;
      assign flags[i] = (mag > lim);
   end

endmodule

// File: rtl/dac_diag_locate.sv
module dac_diag_locate #(
   parameter int N = 4
) (
   input  logic [N-1:0]         flags,
   output logic                 none,
   output logic                 single,
   output logic [$clog2(N)-1:0] index
);

   localparam int IW = $clog2(N);

   if (N < 2) begin : g_bad_n
      $error("dac_diag_locate: need at least two entries");
   end

   assign none   = (flags == '0);
   assign single = ($countones(flags) == 1);

   always_comb begin
      index = '0;
      for (int k = 0; k < N; k++) begin
         if (flags[k]) index = IW'(k);
      end
   end

endmodule

// File: rtl/dac_diag_seq.sv
module dac_diag_seq
   import dac_diag_pkg::*;
#(
   parameter int ROWS   = 4,
   parameter int COLS   = 4,
   parameter int SUM_W  = 16,
   parameter int STEP_W = $clog2(ROWS*COLS + 1)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic [STEP_W-1:0]        est_steps,
   input  logic [SUM_W-1:0]         threshold,
   input  logic                     meas_valid,
   input  logic [SUM_W-1:0]         meas_sum,
   output logic                     meas_req,
   output logic                     test_sel,
   output logic [ROWS*COLS-1:0]     dac_code,
   output logic [ROWS-1:0]          row_en,
   output logic [COLS-1:0]          col_en,
   output logic                     done,
   output logic                     pass,
   output logic                     fault_found,
   output logic                     ambiguous,
   output logic [$clog2(ROWS)-1:0]  fault_row,
   output logic [$clog2(COLS)-1:0]  fault_col
);

   localparam int CELLS = ROWS * COLS;
   localparam int RW    = $clog2(ROWS);
   localparam int CW    = $clog2(COLS);

   if (ROWS < 2 || COLS < 2) begin : g_bad_dim
      $error("dac_diag_seq: matrix must be at least 2x2");
   end
   if (STEP_W < $clog2(CELLS + 1)) begin : g_bad_step
      $error("dac_diag_seq: STEP_W cannot index the matrix");
   end
   if (SUM_W < 4) begin : g_bad_sum
      $error("dac_diag_seq: SUM_W too small");
   end

   seq_state_t              state;
   logic [STEP_W-1:0]       idx;
   logic [STEP_W-1:0]       steps_q;
   logic [ROWS*SUM_W-1:0]   row_sums;
   logic [COLS*SUM_W-1:0]   col_sums;
   verdict_t                verdict;
   logic                    take;
   logic                    begin_run;
   logic [ROWS-1:0]         row_flags;
   logic [COLS-1:0]         col_flags;
   logic                    row_none, row_one, col_none, col_one;
   logic [RW-1:0]           row_idx;
   logic [CW-1:0]           col_idx;
   logic [CELLS-1:0]        ramp_code;

   assign meas_req  = (state == ST_EST) || (state == ST_ROW) || (state == ST_COL);
   assign take      = meas_req && meas_valid;
   assign begin_run = start && ((state == ST_IDLE) || (state == ST_DONE));
   assign test_sel  = (state == ST_ROW) || (state == ST_COL);
   assign done      = (state == ST_DONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         idx       <= '0;
         steps_q   <= '0;
         row_sums  <= '0;
         col_sums  <= '0;
         verdict   <= '0;
         fault_row <= '0;
         fault_col <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_DONE: begin
               if (begin_run) begin
                  verdict   <= '0;
                  fault_row <= '0;
                  fault_col <= '0;
                  steps_q   <= est_steps;
                  idx       <= '0;
                  state     <= (est_steps == '0) ? ST_ROW : ST_EST;
               end
            end
            ST_EST: begin
               if (take) begin
                  if (idx + 1'b1 == steps_q) begin
                     idx   <= '0;
                     state <= ST_ROW;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_ROW: begin
               if (take) begin
                  row_sums[idx*SUM_W +: SUM_W] <= meas_sum;
                  if (idx == STEP_W'(ROWS - 1)) begin
                     idx   <= '0;
                     state <= ST_COL;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_COL: begin
               if (take) begin
                  col_sums[idx*SUM_W +: SUM_W] <= meas_sum;
                  if (idx == STEP_W'(COLS - 1)) begin
                     idx   <= '0;
                     state <= ST_EVAL;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_EVAL: begin
               verdict.pass  <= row_none && col_none;
               verdict.fault <= row_one && col_one;
               verdict.ambig <= !(row_none && col_none) && !(row_one && col_one);
               if (row_one && col_one) begin
                  fault_row <= row_idx;
                  fault_col <= col_idx;
               end
               state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign pass        = verdict.pass;
   assign fault_found = verdict.fault;
   assign ambiguous   = verdict.ambig;

   dac_diag_therm #(.CELLS(CELLS), .STEP_W(STEP_W)) u_therm (
      .level (idx),
      .code  (ramp_code)
   );
   assign dac_code = (state == ST_EST) ? ramp_code : '0;

   for (genvar r = 0; r < ROWS; r++) begin : g_row_en
      assign row_en[r] = (state == ST_COL) || ((state == ST_ROW) && (idx == STEP_W'(r)));
   end
   for (genvar c = 0; c < COLS; c++) begin : g_col_en
      assign col_en[c] = (state == ST_ROW) || ((state == ST_COL) && (idx == STEP_W'(c)));
   end

   dac_diag_outlier #(.N(ROWS), .SUM_W(SUM_W)) u_row_chk (
      .sums      (row_sums),
      .threshold (threshold),
      .flags     (row_flags)
   );
   dac_diag_outlier #(.N(COLS), .SUM_W(SUM_W)) u_col_chk (
      .sums      (col_sums),
      .threshold (threshold),
      .flags     (col_flags)
   );

   dac_diag_locate #(.N(ROWS)) u_row_loc (
      .flags  (row_flags),
      .none   (row_none),
      .single (row_one),
      .index  (row_idx)
   );
   dac_diag_locate #(.N(COLS)) u_col_loc (
      .flags  (col_flags),
      .none   (col_none),
      .single (col_one),
      .index  (col_idx)
   );

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (!meas_req && !done && !test_sel && dac_code == '0 &&
               row_en == '0 && col_en == '0 && !pass && !fault_found && !ambiguous));

   // R5
   hold_sel_chk: assert property (@(posedge clk) disable iff (rst)
      (meas_req && !meas_valid) |=> (meas_req && $stable(row_en) && $stable(col_en) &&
                                     $stable(dac_code) && $stable(test_sel)));

   // R4
   sel_shape_chk: assert property (@(posedge clk) disable iff (rst)
      test_sel |-> (($countones(row_en) == 1 && col_en == '1) ||
                    ($countones(col_en) == 1 && row_en == '1)));

   // R9
   one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> ($countones({pass, fault_found, ambiguous}) == 1));

   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> (done && $stable(pass) && $stable(fault_found) &&
                            $stable(ambiguous) && $stable(fault_row) && $stable(fault_col)));

   // R2
   est_mode_chk: assert property (@(posedge clk) disable iff (rst)
      (meas_req && !test_sel) |-> (row_en == '0 && col_en == '0));

endmodule

// File: tb/tb_dac_diag_seq.sv
`timescale 1ns/1ps
module tb_dac_diag_seq;

   localparam int ROWS  = 4;
   localparam int COLS  = 4;
   localparam int SUM_W = 16;
   localparam int CELLS = ROWS * COLS;
   localparam int STEP_W = $clog2(CELLS + 1);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic [STEP_W-1:0] est_steps = '0;
   logic [SUM_W-1:0]  threshold = '0;
   logic meas_valid = 1'b0;
   logic [SUM_W-1:0]  meas_sum = '0;
   logic meas_req, test_sel, done, pass, fault_found, ambiguous;
   logic [CELLS-1:0] dac_code;
   logic [ROWS-1:0]  row_en;
   logic [COLS-1:0]  col_en;
   logic [1:0] fault_row, fault_col;

   int checks = 0;
   int errors = 0;
   int rv [ROWS];
   int cv [COLS];

   always #10 clk = ~clk;

   dac_diag_seq #(.ROWS(ROWS), .COLS(COLS), .SUM_W(SUM_W)) dut (
      .clk(clk), .rst(rst), .start(start), .est_steps(est_steps),
      .threshold(threshold), .meas_valid(meas_valid), .meas_sum(meas_sum),
      .meas_req(meas_req), .test_sel(test_sel), .dac_code(dac_code),
      .row_en(row_en), .col_en(col_en), .done(done), .pass(pass),
      .fault_found(fault_found), .ambiguous(ambiguous),
      .fault_row(fault_row), .fault_col(fault_col)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int find_one(input logic [3:0] v);
      int r = -1;
      for (int k = 0; k < 4; k++) if (v[k]) r = k;
      return r;
   endfunction

   // kind: 0 pass, 1 fault, 2 ambiguous
   task automatic run(input int est_n, input int thr, input int lat,
                      input int kind, input int er, input int ec, input string tag);
      int est_seen = 0, rows_seen = 0, cols_seen = 0;
      int code_err = 0, ord_err = 0, hold_err = 0, waitc = 0, guard = 0;
      logic [CELLS+ROWS+COLS:0] snap = '0;
      logic [2:0] res;
      est_steps = STEP_W'(est_n);
      threshold = SUM_W'(thr);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      // R10: done and verdict cleared the cycle after start
      check(!done && !pass && !fault_found && !ambiguous, {"R10 clear ", tag},
            int'(done), 0);
      while (!done && guard < 4000) begin
         guard++;
         if (meas_req) begin
            if (waitc == 0) snap = {dac_code, row_en, col_en, test_sel};
            else if (snap != {dac_code, row_en, col_en, test_sel}) hold_err++;
            if (waitc < lat) begin
               meas_valid = 1'b0; waitc++;
            end else begin
               waitc = 0;
               meas_valid = 1'b1;
               if (!test_sel) begin
                  if (dac_code != CELLS'((1 << est_seen) - 1) || rows_seen != 0) code_err++;
                  meas_sum = SUM_W'(est_seen * 10);
                  est_seen++;
               end else if (col_en == '1 && $countones(row_en) == 1) begin
                  if (find_one(row_en) != rows_seen || cols_seen != 0) ord_err++;
                  meas_sum = SUM_W'(rv[find_one(row_en)]);
                  rows_seen++;
               end else if (row_en == '1 && $countones(col_en) == 1) begin
                  if (find_one(col_en) != cols_seen) ord_err++;
                  meas_sum = SUM_W'(cv[find_one(col_en)]);
                  cols_seen++;
               end else ord_err++;
            end
         end else meas_valid = 1'b0;
         @(negedge clk);
      end
      meas_valid = 1'b0;
      check(done == 1'b1, {"R5 run completes ", tag}, int'(done), 1);
      check(est_seen == est_n, {"R2/R3 estimation count ", tag}, est_seen, est_n);
      check(code_err == 0, {"R2 ramp codes ", tag}, code_err, 0);
      check(ord_err == 0 && rows_seen == ROWS && cols_seen == COLS,
            {"R4 row/column order ", tag}, rows_seen * 10 + cols_seen + 100 * ord_err, 44);
      check(hold_err == 0, {"R5 selection hold ", tag}, hold_err, 0);
      res = {pass, fault_found, ambiguous};
      case (kind)
         0: check(res == 3'b100, {"R8 pass ", tag}, int'(res), 4);
         1: begin
            check(res == 3'b010, {"R7 fault flag ", tag}, int'(res), 2);
            check(int'(fault_row) == er && int'(fault_col) == ec, {"R7 location ", tag},
                  int'(fault_row) * 10 + int'(fault_col), er * 10 + ec);
         end
         default: check(res == 3'b001, {"R9 ambiguous ", tag}, int'(res), 1);
      endcase
      // R10 and R5: held through idle cycles while meas_valid toggles without request
      for (int k = 0; k < 4; k++) begin
         meas_valid = k[0];
         meas_sum = 16'h7fff;
         @(negedge clk);
      end
      meas_valid = 1'b0;
      check(done && {pass, fault_found, ambiguous} == res && !meas_req,
            {"R10 result held ", tag}, int'({pass, fault_found, ambiguous}), int'(res));
   endtask

   task automatic set_rows(input int a, input int b, input int c, input int d);
      rv[0] = a; rv[1] = b; rv[2] = c; rv[3] = d;
   endtask
   task automatic set_cols(input int a, input int b, input int c, input int d);
      cv[0] = a; cv[1] = b; cv[2] = c; cv[3] = d;
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(!meas_req && !done && !test_sel && dac_code == '0 && row_en == '0 &&
            col_en == '0 && !pass && !fault_found && !ambiguous,
            "R1 reset state", int'({meas_req, done, test_sel}), 0);
   endtask

   task automatic t_idle_valid;
      meas_valid = 1'b1; meas_sum = 16'd123;
      repeat (3) @(negedge clk);
      meas_valid = 1'b0;
      check(!meas_req && !done && !test_sel, "R5 valid ignored when idle",
            int'({meas_req, done}), 0);
   endtask

   task automatic t_midrun_reset;
      est_steps = STEP_W'(6);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(!meas_req && !done && !test_sel && dac_code == '0 && row_en == '0 && col_en == '0,
            "R11 reset mid-run", int'({meas_req, done, test_sel}), 0);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_idle_valid();
      set_rows(400, 400, 400, 400); set_cols(400, 400, 400, 400);
      run(6, 30, 0, 0, 0, 0, "nominal");
      set_rows(400, 400, 460, 400); set_cols(400, 460, 400, 400);
      run(6, 30, 2, 1, 2, 1, "fault 2,1 with latency");
      run(6, 60, 0, 0, 0, 0, "R6 boundary equal");
      run(6, 59, 1, 1, 2, 1, "R6 boundary below");
      set_rows(300, 400, 400, 400); set_cols(400, 400, 400, 300);
      run(0, 50, 0, 1, 0, 3, "R3 no estimation low fault");
      set_rows(400, 460, 460, 400); set_cols(460, 400, 400, 400);
      run(6, 30, 0, 2, 0, 0, "two rows");
      set_rows(400, 400, 400, 401); set_cols(400, 400, 400, 401);
      run(6, 0, 0, 2, 0, 0, "R6 exact mean");
      run(6, 1, 0, 0, 0, 0, "R6 exact mean thr1");
      set_rows(-400, -340, -400, -400); set_cols(-400, -400, -460, -400);
      run(16, 30, 1, 1, 1, 2, "negative sums full ramp");
      t_midrun_reset();
      set_rows(400, 400, 400, 400); set_cols(400, 400, 400, 460);
      run(3, 30, 0, 2, 0, 0, "R11 after reset");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule